// File: doc/BRIEF.md
# Sampled Input Deglitch Filter

This block takes a digital input that arrives with no timing relation to the system clock and may ring for a while after each edge. It gives the rest of the chip a clean level. The input first passes through a two-flop synchronizer.

A divider then picks sampling instants at a programmable spacing, and a short history register keeps the most recent samples. In a filtering mode the registered output moves to a new level only after every sample in the selected window agrees on that level. Any disagreement leaves the output where it was. The output is a plain register, so a reader never waits on it: the filter setting only changes how soon a new level shows up.

A two-bit mode code picks the filter. Code 0 and code 3 pass the synchronized level straight through. Code 1 requires three agreeing samples and code 2 requires six. The spacing value is set so that the window is longer than the ringing that has to be rejected. For example, a spacing value of 20 at 200 MHz puts 40 clocks between samples, and the five gaps between six samples then cover about 1 us.

Top module: `input_qualifier`

## Requirements
- R1: While reset is low, and on the first clock after it is released, the output `pin_qual` is 0.
- R2: The raw input goes through a two-flop synchronizer. In mode code 0 the output takes a new raw level on the third rising clock edge after the input changes.
- R3: Mode code 3 behaves the same as mode code 0.
- R4: A spacing value of 0 takes a sample on every clock. A nonzero spacing value P takes a sample every 2*P clocks. The history only changes on a sampling clock.
- R5: Mode code 1 changes the output only when the three most recent samples all hold the new level. A pulse three samples long is therefore passed.
- R6: Mode code 2 changes the output only when the six most recent samples all hold the new level. With spacing 0 the output is still old after the eighth rising edge following an input change and new after the ninth.
- R7: In modes 1 and 2, if the samples in the window do not all agree, the output keeps its previous value. With spacing 0, a five-clock pulse in mode 2 never reaches the output.
- R8: With mode code 2 and spacing value 20, a level change on the input reaches the output no sooner than 200 clocks and no later than 250 clocks after the input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| pin_raw | input | 1 | Raw asynchronous input level |
| period_sel | input | PERIOD_W (8) | Sample spacing value; 0 = every clock, else 2*value clocks |
| mode_sel | input | 2 | Filter mode: 0/3 synchronize only, 1 = three samples, 2 = six samples |
| pin_qual | output | 1 | Qualified output level |

## Verification
Some rules are checked by the assertions on every cycle:
- The pass-through follows the synchronizer one cycle later.
- The history stays frozen between sampling clocks.
- Back-to-back sampling happens only with a zero spacing value.
- Any change of the filtered output is backed by a full window of agreeing samples.

Other behaviour can only be shown by the bench's scenarios:
- The absolute latencies counted from the pin.
- The 200 to 250 clock window at spacing 20.
- The contrast between a short pulse that passes mode 1 and one that mode 2 rejects.

// File: rtl/qual_pkg.sv
package qual_pkg;
   typedef enum logic [1:0] {
      QM_SYNC     = 2'd0,
      QM_THREE    = 2'd1,
      QM_SIX      = 2'd2,
      QM_SYNC_ALT = 2'd3
   } qual_mode_e;

   function automatic logic window_agrees(input logic [7:0] bits, input int unsigned len);
      logic ones, zeros;
      ones  = 1'b1;
      zeros = 1'b1;
      for (int i = 0; i < 8; i++) begin
         if (i < int'(len)) begin
            ones  = ones & bits[i];
            zeros = zeros & ~bits[i];
         end
      end
      return ones | zeros;
   endfunction
endpackage

// File: rtl/qual_sync.sv
module qual_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_sys,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("qual_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_async};
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/qual_tick.sv
module qual_tick #(
   parameter int unsigned PERIOD_W = 8
) (
   input  logic                clk_sys,
   input  logic                rst_n,
   input  logic [PERIOD_W-1:0] period_sel,
   output logic                tick
);
   localparam int unsigned CNT_W = PERIOD_W + 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] span;

   assign span = {period_sel, 1'b0};
   assign tick = (period_sel == '0) || (cnt >= span - CNT_W'(1));

   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/qual_history.sv
module qual_history #(
   parameter int unsigned DEPTH = 6
) (
   input  logic             clk_sys,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             sample_in,
   output logic [DEPTH-1:0] hist
);
   generate
      if (DEPTH < 2) begin : g_bad
         $error("qual_history: DEPTH must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n)    hist <= '0;
      else if (tick) hist <= {hist[DEPTH-2:0], sample_in};
   end
endmodule

// File: rtl/input_qualifier.sv
module input_qualifier
   import qual_pkg::*;
#(
   parameter int unsigned PERIOD_W    = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned SHORT_COUNT = 3,
   parameter int unsigned LONG_COUNT  = 6
) (
   input  logic                clk_sys,
   input  logic                rst_n,
   input  logic                pin_raw,
   input  logic [PERIOD_W-1:0] period_sel,
   input  logic [1:0]          mode_sel,
   output logic                pin_qual
);
   localparam int unsigned HIST_W = LONG_COUNT;

   generate
      if (SHORT_COUNT < 2 || SHORT_COUNT > LONG_COUNT) begin : g_bad_short
         $error("input_qualifier: SHORT_COUNT must be in 2..LONG_COUNT");
      end
      if (LONG_COUNT > 8) begin : g_bad_long
         $error("input_qualifier: LONG_COUNT must not exceed 8");
      end
   endgenerate

   logic              pin_sync;
   logic              tick;
   logic [HIST_W-1:0] hist;
   logic [7:0]        hist_pad;
   logic              agree_short;
   logic              agree_long;
   logic              qual_next;
   qual_mode_e        mode;

   qual_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_sys (clk_sys),
      .rst_n   (rst_n),
      .d_async (pin_raw),
      .q_sync  (pin_sync)
   );

   qual_tick #(.PERIOD_W(PERIOD_W)) u_tick (
      .clk_sys    (clk_sys),
      .rst_n      (rst_n),
      .period_sel (period_sel),
      .tick       (tick)
   );

   qual_history #(.DEPTH(HIST_W)) u_hist (
      .clk_sys   (clk_sys),
      .rst_n     (rst_n),
      .tick      (tick),
      .sample_in (pin_sync),
      .hist      (hist)
   );

   generate
      if (HIST_W < 8) begin : g_pad
         assign hist_pad = {{(8-HIST_W){1'b0}}, hist};
      end else begin : g_nopad
         assign hist_pad = hist;
      end
   endgenerate

   assign agree_short = window_agrees(hist_pad, SHORT_COUNT);
   assign agree_long  = window_agrees(hist_pad, LONG_COUNT);
   assign mode        = qual_mode_e'(mode_sel);

   always_comb begin
      qual_next = pin_qual;
      unique case (mode)
         QM_THREE: if (agree_short) qual_next = hist[0];
         QM_SIX:   if (agree_long)  qual_next = hist[0];
         default:  qual_next = pin_sync;
      endcase
   end

   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) pin_qual <= 1'b0;
      else        pin_qual <= qual_next;
   end
endmodule

// File: rtl/qual_checker.sv
module qual_checker #(
   parameter int unsigned PERIOD_W    = 8,
   parameter int unsigned SHORT_COUNT = 3,
   parameter int unsigned LONG_COUNT  = 6
) (
   input logic                  clk_sys,
   input logic                  rst_n,
   input logic [PERIOD_W-1:0]   period_sel,
   input logic [1:0]            mode_sel,
   input logic                  pin_sync,
   input logic                  tick,
   input logic [LONG_COUNT-1:0] hist,
   input logic                  pin_qual
);
   // R1: output is low on the first edge after reset is released
   assert_reset_low_R1: assert property (@(posedge clk_sys)
      $rose(rst_n) |-> !pin_qual);

   // R2, R3: bypass modes follow the synchronizer one clock later
   assert_bypass_follow_R2: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (mode_sel == 2'd0 || mode_sel == 2'd3) |=> (pin_qual == $past(pin_sync)));

   // R4: history is frozen between sampling clocks
   assert_hist_frozen_R4: assert property (@(posedge clk_sys) disable iff (!rst_n)
      !tick |=> $stable(hist));

   // R4: with a nonzero spacing, two samples are never adjacent
   assert_tick_spacing_R4: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (tick && period_sel != '0) |=> (period_sel == '0 || !tick));

   // R4: spacing zero samples every clock
   assert_tick_every_R4: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (period_sel == '0) |-> tick);

   // R5, R7: a change in three-sample mode is backed by three agreeing samples
   assert_short_agree_R5: assert property (@(posedge clk_sys) disable iff (!rst_n)
      ((pin_qual != $past(pin_qual)) && $past(mode_sel) == 2'd1)
         |-> ($past(hist[SHORT_COUNT-1:0]) == {SHORT_COUNT{pin_qual}}));

   // R6, R7: a change in six-sample mode is backed by six agreeing samples
   assert_long_agree_R6: assert property (@(posedge clk_sys) disable iff (!rst_n)
      ((pin_qual != $past(pin_qual)) && $past(mode_sel) == 2'd2)
         |-> ($past(hist) == {LONG_COUNT{pin_qual}}));
endmodule

bind input_qualifier qual_checker #(
   .PERIOD_W    (PERIOD_W),
   .SHORT_COUNT (SHORT_COUNT),
   .LONG_COUNT  (LONG_COUNT)
) u_chk (
   .clk_sys    (clk_sys),
   .rst_n      (rst_n),
   .period_sel (period_sel),
   .mode_sel   (mode_sel),
   .pin_sync   (pin_sync),
   .tick       (tick),
   .hist       (hist),
   .pin_qual   (pin_qual)
);

// File: tb/sim_input_qualifier.sv
`timescale 1ns/1ps
module sim_input_qualifier;
   logic       clk_sys = 1'b0;
   logic       rst_n   = 1'b0;
   logic       pin_raw = 1'b0;
   logic [7:0] period_sel = 8'd0;
   logic [1:0] mode_sel   = 2'd0;
   logic       pin_qual;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk_sys = ~clk_sys;

   input_qualifier u0 (
      .clk_sys    (clk_sys),
      .rst_n      (rst_n),
      .pin_raw    (pin_raw),
      .period_sel (period_sel),
      .mode_sel   (mode_sel),
      .pin_qual   (pin_qual)
   );

   // columns: mode, spacing, level, wait clocks, expected output
   localparam int VEC [8][5] = '{
      '{0, 0, 1, 10, 1},
      '{0, 0, 0, 10, 0},
      '{1, 0, 1, 10, 1},
      '{1, 3, 0, 40, 0},
      '{2, 0, 1, 12, 1},
      '{2, 2, 0, 40, 0},
      '{3, 0, 1,  5, 1},
      '{2, 1, 0, 30, 0}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clocks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk_sys);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state with the pin held high in six-sample mode
      pin_raw  = 1'b1;
      mode_sel = 2'd2;
      clocks(3);
      check(pin_qual == 1'b0, "R1 during reset", pin_qual, 0);
      rst_n = 1'b1;
      clocks(1);
      check(pin_qual == 1'b0, "R1 after release", pin_qual, 0);
      pin_raw = 1'b0;
      clocks(20);

      // table walk: R2 R3 R4 R5 R6
      for (int i = 0; i < 8; i++) begin
         mode_sel   = 2'(VEC[i][0]);
         period_sel = 8'(VEC[i][1]);
         pin_raw    = 1'(VEC[i][2]);
         clocks(VEC[i][3]);
         check(pin_qual == 1'(VEC[i][4]),
               $sformatf("R2/R3/R4/R5/R6 vector %0d", i), pin_qual, VEC[i][4]);
      end

      // R2: exact bypass latency
      mode_sel = 2'd0; period_sel = 8'd0; pin_raw = 1'b0;
      clocks(10);
      pin_raw = 1'b1;
      clocks(2);
      check(pin_qual == 1'b0, "R2 old after two edges", pin_qual, 0);
      clocks(1);
      check(pin_qual == 1'b1, "R2 new after three edges", pin_qual, 1);

      // R3: mode 3 has the same latency
      mode_sel = 2'd3;
      pin_raw  = 1'b0;
      clocks(2);
      check(pin_qual == 1'b1, "R3 old after two edges", pin_qual, 1);
      clocks(1);
      check(pin_qual == 1'b0, "R3 new after three edges", pin_qual, 0);

      // R6: exact six-sample latency at spacing 0
      mode_sel = 2'd2;
      clocks(12);
      pin_raw = 1'b1;
      clocks(8);
      check(pin_qual == 1'b0, "R6 old after eight edges", pin_qual, 0);
      clocks(1);
      check(pin_qual == 1'b1, "R6 new after nine edges", pin_qual, 1);
      pin_raw = 1'b0;
      clocks(12);

      // R7: five-clock pulse rejected in six-sample mode
      begin
         bit seen = 1'b0;
         pin_raw = 1'b1;
         for (int i = 0; i < 25; i++) begin
            if (i == 5) pin_raw = 1'b0;
            clocks(1);
            if (pin_qual) seen = 1'b1;
         end
         check(!seen, "R7 pulse rejected", seen, 0);
      end

      // R5: three-clock pulse passes in three-sample mode
      begin
         bit seen = 1'b0;
         mode_sel = 2'd1;
         clocks(8);
         pin_raw = 1'b1;
         for (int i = 0; i < 20; i++) begin
            if (i == 3) pin_raw = 1'b0;
            clocks(1);
            if (pin_qual) seen = 1'b1;
         end
         check(seen, "R5 short pulse passed", seen, 1);
         check(pin_qual == 1'b0, "R5 returns low", pin_qual, 0);
      end

      // R4: spacing 4 gives 8-clock samples, so a 7-clock pulse in mode 1 may be sampled at most once
      begin
         bit seen = 1'b0;
         period_sel = 8'd4;
         clocks(60);
         pin_raw = 1'b1;
         for (int i = 0; i < 60; i++) begin
            if (i == 7) pin_raw = 1'b0;
            clocks(1);
            if (pin_qual) seen = 1'b1;
         end
         check(!seen, "R4 sparse sampling ignores short pulse", seen, 0);
      end

      // R8: spacing 20 in six-sample mode
      mode_sel = 2'd2; period_sel = 8'd20; pin_raw = 1'b0;
      clocks(300);
      pin_raw = 1'b1;
      clocks(200);
      check(pin_qual == 1'b0, "R8 still old at 200 clocks", pin_qual, 0);
      clocks(50);
      check(pin_qual == 1'b1, "R8 new by 250 clocks", pin_qual, 1);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule